// File: doc/BRIEF.md
# Sampling Speed and Power State Controller

This block sits in the control path of a stereo audio converter. It works out at which speed the converter's sample path runs: half, normal or double. It also decides whether that path is powered, in power save or held in full power-down. Two select pins either fix the speed directly or choose automatic detection. In automatic detection the speed follows the measured ratio of master clock to frame clock.

The ratio is measured in the system clock domain. Upstream logic supplies a one-cycle pulse for every master clock edge (`mclk_tick`) and for every rising frame clock edge (`frame_rise`). The block counts master clock pulses per frame and accepts a count only when two consecutive frames agree. If either clock falls silent for a fixed timeout while the block is running, it enters power save and asks for a midscale (mute) output. A de-emphasis request passes through only in the select settings where de-emphasis is permitted.

Top module: `speed_power_ctrl`

## Requirements
- R1: After reset the block is in power-down (`st_pdown`=1, `hiz`=1), with `speed`=00, `ratio`=0, `ratio_err`=0 and `deemph_en`=0.
- R2: The speed code is 00 for normal, 01 for double and 10 for half. With `sel` at 00, 01 or 10, an accepted valid ratio sets `speed` equal to `sel`. The code 11 never appears on `speed`.
- R3: The valid ratios for each select setting are as follows. With `sel`=00 they are 256, 384, 512 and 768. With `sel`=01 they are 128, 192, 256 and 384. With `sel`=10 they are 512, 768, 1024 and 1536. An accepted valid ratio also appears on `ratio`.
- R4: With `sel`=11 (automatic), ratios 512 and 768 give normal speed, 1024 and 1536 give half speed, and 128, 192, 256 and 384 give double speed. Any other ratio is invalid.
- R5: The ratio is the number of `mclk_tick` pulses between two successive `frame_rise` pulses. It is accepted only when two consecutive frames have the same count. The first frame after reset, and the first frame after a detected stop, is discarded. Counts that alternate between frames never change `ratio`.
- R6: An accepted ratio that is invalid for the current `sel` leaves `speed` and `ratio` unchanged and sets `ratio_err`. The next accepted valid ratio clears `ratio_err`.
- R7: Exactly one of `st_pdown`, `st_run` and `st_save` is high at all times. The block leaves power-down for the run state only on an accepted measurement while `pd_n` is high and neither clock is stopped. Without such a measurement it stays in power-down.
- R8: When `pd_n` is low, the block is in power-down with `hiz`=1 from the next cycle on, whatever state it was in before.
- R9: In the run state, a stop is declared when TIMEOUT (2048) system cycles pass without a `frame_rise`, or without an `mclk_tick`. The block then enters power save with `mid_req`=1 and `hiz`=0. It is still running 2000 cycles after the last activity.
- R10: From power save, the block returns to the run state on the next accepted measurement taken with both clocks active.
- R11: One cycle after the inputs, `deemph_en` equals `deemph_req` when `sel` is 00 or 11, and is 0 when `sel` is 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_tick | input | 1 | One pulse per master clock edge, already in the `clk` domain |
| frame_rise | input | 1 | One pulse per rising frame clock edge, already in the `clk` domain |
| pd_n | input | 1 | Power-down pin, low forces full power-down |
| sel | input | 2 | Speed select: 00 normal, 01 double, 10 half, 11 automatic |
| deemph_req | input | 1 | De-emphasis request |
| speed | output | 2 | Current speed code: 00 normal, 01 double, 10 half |
| ratio | output | CNT_W | Last accepted valid master-clock-to-frame ratio |
| st_pdown | output | 1 | Power-down state flag |
| st_run | output | 1 | Run state flag |
| st_save | output | 1 | Power-save state flag |
| hiz | output | 1 | Output high-impedance; sample filters held in reset |
| mid_req | output | 1 | Request midscale (mute) output |
| ratio_err | output | 1 | Last accepted ratio was invalid |
| deemph_en | output | 1 | Gated de-emphasis enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an accepted measurement and a change of the power pin. The bench provokes it by dropping `pd_n` while a locked frame stream keeps producing acceptances, and judges that power-down wins and that no acceptance while the pin is low can reach the run state. The second pair is stop detection and the resume measurement. When clocks restart after a silence, the first frame edge arrives while the frame timer is still expired. The bench confirms that this frame is discarded and that the block resumes only after a full set of agreeing frames, and a checker confirms that power save is never left without an accepted measurement.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    SEL_NORMAL = 2'b00,
    SEL_DOUBLE = 2'b01,
    SEL_HALF   = 2'b10,
    SEL_AUTO   = 2'b11
  } sel_t;

  typedef enum logic [1:0] {
    PW_DOWN = 2'd0,
    PW_RUN  = 2'd1,
    PW_SAVE = 2'd2
  } pwr_t;

  typedef struct packed {
    logic       ok;
    logic [1:0] spd;
  } pick_t;

  // Ratio legality for one fixed speed.
  function automatic logic ratio_fits(logic [1:0] spd, int unsigned r);
    case (spd)
      SEL_NORMAL: ratio_fits = (r == 256) || (r == 384) || (r == 512) || (r == 768);
      SEL_DOUBLE: ratio_fits = (r == 128) || (r == 192) || (r == 256) || (r == 384);
      SEL_HALF:   ratio_fits = (r == 512) || (r == 768) || (r == 1024) || (r == 1536);
      default:    ratio_fits = 1'b0;
    endcase
  endfunction

  // Speed chosen for a measured ratio under a given select setting.
  function automatic pick_t speed_pick(logic [1:0] sel, int unsigned r);
    pick_t p;
    p.ok  = 1'b0;
    p.spd = SEL_NORMAL;
    if (sel == SEL_AUTO) begin
      if ((r == 512) || (r == 768)) begin
        p.ok  = 1'b1;
        p.spd = SEL_NORMAL;
      end else if ((r == 1024) || (r == 1536)) begin
        p.ok  = 1'b1;
        p.spd = SEL_HALF;
      end else if (ratio_fits(SEL_DOUBLE, r)) begin
        p.ok  = 1'b1;
        p.spd = SEL_DOUBLE;
      end
    end else begin
      p.ok  = ratio_fits(sel, r);
      p.spd = sel;
    end
    return p;
  endfunction

  function automatic logic deemph_allowed(logic [1:0] sel);
    return (sel == SEL_NORMAL) || (sel == SEL_AUTO);
  endfunction

endpackage

// File: rtl/spc_ratio_meter.sv
module spc_ratio_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frame,
  input  logic             flush,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_val
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             primed;
  logic             last_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      last     <= '0;
      primed   <= 1'b0;
      last_ok  <= 1'b0;
      meas_vld <= 1'b0;
      meas_val <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (flush) begin
        cnt     <= '0;
        primed  <= 1'b0;
        last_ok <= 1'b0;
      end else if (frame) begin
        cnt <= tick ? CNT_W'(1) : '0;
        if (!primed) begin
          primed <= 1'b1;
        end else begin
          last    <= cnt;
          last_ok <= 1'b1;
          if (last_ok && (cnt == last)) begin
            meas_vld <= 1'b1;
            meas_val <= cnt;
          end
        end
      end else if (tick && (cnt != SAT)) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spc_clk_watch.sv
module spc_clk_watch #(
  parameter int TIMEOUT = 2048,
  parameter int N_CH    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] evt,
  output logic            stopped
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT);

  logic [N_CH-1:0] expired;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [TW-1:0] tmr;
    always_ff @(posedge clk) begin
      if (!rst_n)             tmr <= '0;
      else if (evt[g])        tmr <= '0;
      else if (tmr != LIMIT)  tmr <= tmr + TW'(1);
    end
    assign expired[g] = (tmr == LIMIT);
  end

  assign stopped = |expired;
endmodule

// File: rtl/spc_power_fsm.sv
module spc_power_fsm
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic meas_vld,
  input  logic stopped,
  output pwr_t state
);
  pwr_t nxt;
  logic clocks_ok;

  assign clocks_ok = meas_vld && !stopped;

  always_comb begin
    nxt = state;
    if (!pd_n) begin
      nxt = PW_DOWN;
    end else begin
      case (state)
        PW_DOWN: if (clocks_ok) nxt = PW_RUN;
        PW_RUN:  if (stopped)   nxt = PW_SAVE;
        PW_SAVE: if (clocks_ok) nxt = PW_RUN;
        default: nxt = PW_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PW_DOWN;
    else        state <= nxt;
  end
endmodule

// File: rtl/speed_power_ctrl.sv
module speed_power_ctrl
  import spc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int TIMEOUT = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_tick,
  input  logic             frame_rise,
  input  logic             pd_n,
  input  logic [1:0]       sel,
  input  logic             deemph_req,
  output logic [1:0]       speed,
  output logic [CNT_W-1:0] ratio,
  output logic             st_pdown,
  output logic             st_run,
  output logic             st_save,
  output logic             hiz,
  output logic             mid_req,
  output logic             ratio_err,
  output logic             deemph_en
);
  // Internal events, named for the checker.
  logic             meas_vld;
  logic [CNT_W-1:0] meas_val;
  logic             stopped;
  logic             accept_ok;
  pick_t            pick;
  pwr_t             pstate;

  spc_ratio_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (mclk_tick),
    .frame    (frame_rise),
    .flush    (stopped),
    .meas_vld (meas_vld),
    .meas_val (meas_val)
  );

  spc_clk_watch #(.TIMEOUT(TIMEOUT), .N_CH(2)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     ({frame_rise, mclk_tick}),
    .stopped (stopped)
  );

  spc_power_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .meas_vld (meas_vld),
    .stopped  (stopped),
    .state    (pstate)
  );

  always_comb begin
    pick      = speed_pick(sel, 32'(meas_val));
    accept_ok = pick.ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      speed     <= SEL_NORMAL;
      ratio     <= '0;
      ratio_err <= 1'b0;
      deemph_en <= 1'b0;
    end else begin
      deemph_en <= deemph_req && deemph_allowed(sel);
      if (meas_vld) begin
        if (accept_ok) begin
          speed     <= pick.spd;
          ratio     <= meas_val;
          ratio_err <= 1'b0;
        end else begin
          ratio_err <= 1'b1;
        end
      end
    end
  end

  assign st_pdown = (pstate == PW_DOWN);
  assign st_run   = (pstate == PW_RUN);
  assign st_save  = (pstate == PW_SAVE);
  assign hiz      = st_pdown;
  assign mid_req  = st_save;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_n,
  input logic [1:0]       sel,
  input logic             meas_vld,
  input logic             accept_ok,
  input logic             stopped,
  input logic [1:0]       speed,
  input logic [CNT_W-1:0] ratio,
  input logic             st_pdown,
  input logic             st_run,
  input logic             st_save,
  input logic             hiz,
  input logic             mid_req,
  input logic             ratio_err,
  input logic             deemph_en
);
  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({st_pdown, st_run, st_save})); // R7

  AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_pdown) |-> $past(meas_vld) && $past(pd_n) && !$past(stopped)); // R7

  AST_PIN_FORCES_PDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> st_pdown && hiz); // R8

  AST_SAVE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    st_save |-> mid_req && !hiz); // R9

  AST_STOP_TO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && pd_n && stopped) |=> st_save); // R9

  AST_SAVE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_save) && st_run) |-> $past(meas_vld)); // R10

  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> $stable(speed) && $stable(ratio)); // R6

  AST_BAD_RATIO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !accept_ok) |=> ratio_err && $stable(speed) && $stable(ratio)); // R6

  AST_SPEED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    speed != 2'b11); // R2

  AST_DEEMPH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    deemph_en |-> ($past(sel) != 2'b01) && ($past(sel) != 2'b10)); // R11
endmodule

bind speed_power_ctrl spc_checker #(.CNT_W(CNT_W)) u_spc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pd_n      (pd_n),
  .sel       (sel),
  .meas_vld  (meas_vld),
  .accept_ok (accept_ok),
  .stopped   (stopped),
  .speed     (speed),
  .ratio     (ratio),
  .st_pdown  (st_pdown),
  .st_run    (st_run),
  .st_save   (st_save),
  .hiz       (hiz),
  .mid_req   (mid_req),
  .ratio_err (ratio_err),
  .deemph_en (deemph_en)
);

// File: tb/speed_power_ctrl_bench.sv
`timescale 1ns/1ps
module speed_power_ctrl_bench;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mclk_tick = 1'b0;
  logic             frame_rise = 1'b0;
  logic             pd_n = 1'b1;
  logic [1:0]       sel = 2'b00;
  logic             deemph_req = 1'b0;
  logic [1:0]       speed;
  logic [CNT_W-1:0] ratio;
  logic             st_pdown, st_run, st_save, hiz, mid_req, ratio_err, deemph_en;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  speed_power_ctrl #(.CNT_W(CNT_W), .TIMEOUT(2048)) u_speed_power_ctrl (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .frame_rise(frame_rise),
    .pd_n(pd_n), .sel(sel), .deemph_req(deemph_req), .speed(speed), .ratio(ratio),
    .st_pdown(st_pdown), .st_run(st_run), .st_save(st_save), .hiz(hiz),
    .mid_req(mid_req), .ratio_err(ratio_err), .deemph_en(deemph_en)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame: n master clock pulses, then one frame edge.
  task automatic send_frames(input int n, input int frames);
    for (int f = 0; f < frames; f++) begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk); mclk_tick = 1'b1;
      end
      @(negedge clk); mclk_tick = 1'b0; frame_rise = 1'b1;
      @(negedge clk); frame_rise = 1'b0;
    end
    idle(3);
  endtask

  // Expected speed in the bench's own terms.
  function automatic int exp_speed(input int s, input int r, input int prev);
    int legal[4];
    if (s == 3) begin
      if (r == 512 || r == 768) return 0;
      if (r == 1024 || r == 1536) return 2;
      if (r == 128 || r == 192 || r == 256 || r == 384) return 1;
      return prev;
    end
    case (s)
      0: legal = '{256, 384, 512, 768};
      1: legal = '{128, 192, 256, 384};
      default: legal = '{512, 768, 1024, 1536};
    endcase
    foreach (legal[k]) if (legal[k] == r) return s;
    return prev;
  endfunction

  task automatic t_reset;
    check("R1 pdown", st_pdown, 1);
    check("R1 hiz", hiz, 1);
    check("R1 speed", speed, 0);
    check("R1 ratio", ratio, 0);
    check("R1 err", ratio_err, 0);
    check("R1 deemph", deemph_en, 0);
  endtask

  task automatic t_wait_clocks;
    idle(200);
    check("R7 no clocks stays pdown", st_pdown, 1);
    send_frames(256, 2);
    check("R5 no repeat yet, pdown", st_pdown, 1);
    check("R5 ratio untouched", ratio, 0);
    send_frames(256, 2);
    check("R7 run after lock", st_run, 1);
    check("R3 ratio 256", ratio, 256);
  endtask

  task automatic t_pin_modes;
    int pins[3] = '{1, 2, 0};
    int rats[3] = '{128, 1536, 384};
    for (int k = 0; k < 3; k++) begin
      sel = 2'(pins[k]);
      send_frames(rats[k], 4);
      check("R2 pin speed", speed, exp_speed(pins[k], rats[k], -1));
      check("R3 pin ratio", ratio, rats[k]);
      check("R6 err clear", ratio_err, 0);
    end
  endtask

  task automatic t_bad_ratio;
    sel = 2'b00;
    send_frames(300, 4);
    check("R6 err on 300", ratio_err, 1);
    check("R6 speed kept", speed, 0);
    check("R6 ratio kept", ratio, 384);
    sel = 2'b01;
    send_frames(512, 4);
    check("R6 double rejects 512", ratio_err, 1);
    check("R6 speed kept", speed, 0);
    send_frames(192, 4);
    check("R6 err cleared", ratio_err, 0);
    check("R2 double", speed, 1);
    check("R3 ratio 192", ratio, 192);
  endtask

  task automatic t_alternate;
    for (int k = 0; k < 3; k++) begin
      send_frames(384, 1);
      send_frames(256, 1);
    end
    check("R5 alternating ignored", ratio, 192);
  endtask

  task automatic t_auto;
    int rats[5] = '{768, 1024, 384, 512, 640};
    int prev;
    sel = 2'b11;
    for (int k = 0; k < 5; k++) begin
      prev = speed;
      send_frames(rats[k], 4);
      check("R4 auto speed", speed, exp_speed(3, rats[k], prev));
      check("R4 auto err", ratio_err, (k == 4) ? 1 : 0);
    end
  endtask

  task automatic t_deemph;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); deemph_req = 1'b1;
      @(negedge clk);
      check("R11 deemph gate", deemph_en, (s == 0 || s == 3) ? 1 : 0);
      deemph_req = 1'b0;
      @(negedge clk);
      check("R11 deemph off", deemph_en, 0);
    end
  endtask

  task automatic t_stop_both;
    sel = 2'b00;
    send_frames(512, 4);
    check("R7 running", st_run, 1);
    idle(1995);
    check("R9 not yet stopped", st_run, 1);
    idle(100);
    check("R9 save", st_save, 1);
    check("R9 midscale", mid_req, 1);
    check("R9 not hiz", hiz, 0);
    send_frames(512, 5);
    check("R10 resumed", st_run, 1);
    check("R10 mid off", mid_req, 0);
  endtask

  task automatic t_stop_mclk;
    for (int k = 0; k < 14; k++) begin
      idle(199);
      frame_rise = 1'b1;
      @(negedge clk); frame_rise = 1'b0;
    end
    check("R9 mclk-only stop", st_save, 1);
    check("R10 zero-count keeps ratio", ratio, 512);
    send_frames(256, 5);
    check("R10 resumed again", st_run, 1);
  endtask

  task automatic t_pin_down;
    pd_n = 1'b0;
    @(negedge clk);
    check("R8 pdown", st_pdown, 1);
    check("R8 hiz", hiz, 1);
    send_frames(256, 4);
    check("R8 stays pdown with clocks", st_pdown, 1);
    pd_n = 1'b1;
    send_frames(256, 4);
    check("R7 run after pin high", st_run, 1);
    check("R3 ratio kept", ratio, 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wait_clocks();
    t_pin_modes();
    t_bad_ratio();
    t_alternate();
    t_auto();
    t_deemph();
    t_stop_both();
    t_stop_mclk();
    t_pin_down();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule